// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block holds the general-purpose registers of a simple datapath. It has thirty-two words of thirty-two bits. Two read ports work at the same time and do not depend on each other. Each read port takes a 5-bit register number and returns that register's contents through a combinational selector. The read data is ready within the cycle, so the operand path to the ALU needs no extra register stage.

One write port takes a register number, a data word and an enable. The register number goes through a decoder that raises exactly one per-word write strobe. That word's flip-flops load on the falling clock edge. Rising-edge logic that reads the same register later in the same cycle therefore already sees the new value, and no forwarding network is needed.

Word zero is a constant zero and holds no storage. Writes aimed at it have no effect. An active-low reset clears every stored word.

Top module: `regfile_2r1w`

## Requirements
- R1: Each read port returns the contents of the register whose 5-bit number is on its address input, combinationally, with no clock edge in between.
- R2: The two read ports are independent: any pair of addresses may be read at once, and equal addresses give equal data.
- R3: When the write enable is 1, the write data is stored into the addressed register on the falling clock edge, and it is readable before the next rising edge.
- R4: The write number is decoded to a one-hot strobe: a write changes only the addressed register, and every other register keeps its value.
- R5: While the write enable is 0, no register changes, whatever is on the write address and write data inputs.
- R6: Register number 0 always reads as 0, and writes addressed to it are dropped.
- R7: Driving the active-low reset to 0 clears every register to 0 at once, without waiting for a clock edge.
- R8: When a read and a write address the same register in one cycle, the read port shows the old value until the falling edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its falling edge |
| rst_n | input | 1 | Asynchronous active-low clear, released synchronously by the system |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Contents of the register selected by rd_addr_a |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Contents of the register selected by rd_addr_b |
| wr_addr | input | 5 | Register number for the write port |
| wr_data | input | 32 | Word to store |
| wr_en | input | 1 | Write enable; 1 stores wr_data on the next falling edge |

## Verification
Some properties are checked on every cycle. The write strobe must stay one-hot or idle, and it must be idle when the enable is low. Each stored word must load its input after a strobed falling edge and hold otherwise. Word zero must read as zero, and equal read addresses must give equal data. Other behaviour shows only in the bench's scenarios: the full sweep of address pairs against the value each register was given, the old-then-new view across the falling edge of a same-cycle read and write, the dropped write to word zero, and the clear on reset with no clock edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_NREG = 32;
  localparam int unsigned RF_XLEN = 32;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned NREG      = 32,
  parameter bit          SKIP_ZERO = 1'b1,
  localparam int unsigned AW       = $clog2(NREG)
) (
  input  logic [AW-1:0]   addr,
  input  logic            en,
  output logic [NREG-1:0] sel
);
  localparam int unsigned FIRST = SKIP_ZERO ? 1 : 0;

  always_comb begin
    sel = '0;
    for (int i = FIRST; i < NREG; i++) begin
      if (en && (addr == AW'(i))) sel[i] = 1'b1;
    end
  end

  // R4: at most one word strobed; R5: nothing strobed when disabled
  always_comb begin
    a_r4_onehot: assert ($onehot0(sel)) else $error("write strobe not one-hot");
    if (!en) begin
      a_r5_idle: assert (sel == '0) else $error("strobe active while disabled");
    end
  end
endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  logic [XLEN-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R3: strobed falling edge loads the data word
  a_r3_load: assert property (@(negedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));
  // R5: unstrobed falling edge keeps the word
  a_r5_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][XLEN-1:0] words,
  input  logic [AW-1:0]             addr,
  output logic [XLEN-1:0]           data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(i)) data = words[i];
    end
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
  import rf_pkg::*;
#(
  parameter int unsigned NREG = RF_NREG,
  parameter int unsigned XLEN = RF_XLEN,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            wr_en
);
  logic [NREG-1:0]            wr_sel;
  logic [NREG-1:0][XLEN-1:0]  words;

  rf_wr_decode #(.NREG(NREG), .SKIP_ZERO(1'b1)) u_dec (
    .addr (wr_addr),
    .en   (wr_en),
    .sel  (wr_sel)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_word
    if (g == 0) begin : g_zero
      assign words[g] = '0;
      // R6: word zero is never strobed
      always_comb begin
        a_r6_no_strobe: assert (wr_sel[g] == 1'b0) else $error("word zero strobed");
      end
    end else begin : g_store
      rf_word #(.XLEN(XLEN)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_sel[g]),
        .d     (wr_data),
        .q     (words[g])
      );
    end
  end

  rf_read_mux #(.NREG(NREG), .XLEN(XLEN)) u_mux_a (
    .words (words),
    .addr  (rd_addr_a),
    .data  (rd_data_a)
  );

  rf_read_mux #(.NREG(NREG), .XLEN(XLEN)) u_mux_b (
    .words (words),
    .addr  (rd_addr_b),
    .data  (rd_data_b)
  );

  // R6: register number 0 reads as zero on either port
  a_r6_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  a_r6_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));
  // R2: equal read addresses give equal data
  a_r2_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
endmodule

// File: tb/regfile_2r1w_bench.sv
module regfile_2r1w_bench;
  localparam int unsigned NREG = 32;
  localparam int unsigned XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic [4:0]      rd_addr_a, rd_addr_b, wr_addr;
  logic [XLEN-1:0] rd_data_a, rd_data_b, wr_data;
  logic            wr_en;

  logic [XLEN-1:0] model [NREG];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  regfile_2r1w u_regfile_2r1w (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [XLEN-1:0] pat(int i, logic [XLEN-1:0] salt);
    return (32'h9E3779B9 * (i + 1)) ^ salt;
  endfunction

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(int a, logic [XLEN-1:0] d);
    @(posedge clk); #1;
    wr_addr = 5'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk); #1;
    wr_en = 1'b0;
    if (a != 0) model[a] = d;
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < NREG; a++) begin
      for (int b = 0; b < NREG; b++) begin
        rd_addr_a = 5'(a); rd_addr_b = 5'(b); #1;
        check(req, rd_data_a, model[a]);
        check(req, rd_data_b, model[b]);
      end
    end
  endtask

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    #2 rst_n = 1'b0;
    #1;
    // R7: all registers clear under reset
    for (int i = 0; i < NREG; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(NREG - 1 - i); #1;
      check("R7", rd_data_a, '0);
      check("R7", rd_data_b, '0);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R3/R4: fill every register, including a dropped write to word 0 (R6)
    for (int i = 0; i < NREG; i++) do_write(i, pat(i, 32'h0F1E2D3C));
    // R1/R2/R4/R6: every pair of addresses on both ports
    sweep("R1");

    // R8: same-cycle read of the register being written
    @(posedge clk); #1;
    rd_addr_a = 5'd5; rd_addr_b = 5'd5;
    wr_addr = 5'd5; wr_data = 32'hCAFE0005; wr_en = 1'b1;
    #1;
    check("R8", rd_data_a, model[5]);
    check("R8", rd_data_b, model[5]);
    @(negedge clk); #1;
    wr_en = 1'b0;
    model[5] = 32'hCAFE0005;
    check("R3", rd_data_a, 32'hCAFE0005);
    check("R8", rd_data_b, 32'hCAFE0005);

    // R5: disabled write across several edges leaves the target unchanged
    @(posedge clk); #1;
    wr_addr = 5'd7; wr_data = 32'hDEADBEEF; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    #1 rd_addr_a = 5'd7; #1;
    check("R5", rd_data_a, model[7]);

    // R6: explicit write to register 0 is dropped
    do_write(0, 32'hFFFFFFFF);
    rd_addr_a = 5'd0; rd_addr_b = 5'd0; #1;
    check("R6", rd_data_a, '0);
    check("R6", rd_data_b, '0);

    // R4: one more write, then confirm only that word moved
    do_write(31, 32'h13572468);
    sweep("R4");

    // R7: asynchronous clear mid-cycle, no clock edge needed
    @(posedge clk); #1;
    rd_addr_a = 5'd3; rd_addr_b = 5'd31;
    rst_n = 1'b0; #1;
    check("R7", rd_data_a, '0);
    check("R7", rd_data_b, '0);
    for (int i = 0; i < NREG; i++) model[i] = '0;
    sweep("R7");
    @(posedge clk); #1 rst_n = 1'b1;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule